// File: doc/BRIEF.md
# Endpoint Receive Byte Counter

This block tallies how many data bytes an OUT packet has delivered into one endpoint's receive buffer. Each byte strobe from the packet engine adds one to the tally. The tally never grows past the endpoint's programmed maximum packet size. A short packet therefore leaves a smaller value, which stays put once the end of the packet raises the packet-ready flag. Firmware then uses that value to know how many bytes to drain from the buffer.

The count clears when:
- a new OUT token arrives for the endpoint;
- firmware writes 0 to the packet-ready control;
- firmware writes 0 to the stall control.

Hardware reset and bus reset also return the block to its idle state. While the endpoint is set to transmit, the tally is frozen and has no meaning. Firmware reads the count one byte at a time through a small register window: a low byte and a high byte.

Top module: `rx_byte_tally`

## Requirements
- R1: When `rst_n` is low, or in the cycle after `bus_rst` is high, the count, `pkt_rdy` and `stall` all read 0.
- R2: A `byte_wr` pulse while receiving adds exactly 1 to the count in the next cycle. Receiving means `dir_tx`=0, `pkt_rdy`=0, count below `max_pkt` and no clear event. A short packet's count is then held for reading.
- R3: The count never exceeds `max_pkt`. Strobes that arrive at the limit leave it unchanged, and with `max_pkt`=0 the count stays 0.
- R4: `pkt_end` with `dir_tx`=0 sets `pkt_rdy` in the next cycle. A strobe in that same cycle is still counted. While `pkt_rdy` is 1, strobes leave the count unchanged.
- R5: `out_tok` clears the count in the next cycle and leaves `pkt_rdy` unchanged.
- R6: A write with `wr_sel`=3 and `wr_bit`=0 clears both the count and `pkt_rdy`. With `wr_bit`=1 that write has no effect.
- R7: A write with `wr_sel`=2 loads `stall` from `wr_bit`. When `wr_bit`=0 it also clears the count. When `wr_bit`=1 it leaves the count unchanged.
- R8: If a clear event and a byte strobe fall in the same cycle, the count becomes 0.
- R9: With `dir_tx`=1, strobes and `pkt_end` are ignored. The count and `pkt_rdy` hold.
- R10: `rd_sel`=0 returns count bits [7:0] on `rd_data`, and `rd_sel`=1 returns count bits above 7. Bits beyond the count width read 0, and the read is combinational.
- R11: Writes with `wr_sel`=0 or 1, which are the count register addresses, leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| bus_rst | input | 1 | Synchronous bus reset pulse |
| byte_wr | input | 1 | One received data byte written to the buffer |
| pkt_end | input | 1 | End of the current OUT packet |
| out_tok | input | 1 | OUT token addressed to this endpoint |
| wr_en | input | 1 | Firmware register write strobe |
| wr_sel | input | 2 | Write target: 0/1 count bytes, 2 stall, 3 packet ready |
| wr_bit | input | 1 | Written bit value |
| dir_tx | input | 1 | Endpoint configured for transmit |
| max_pkt | input | CNT_W | Maximum packet size |
| rd_sel | input | 1 | Read byte select: 0 low, 1 high |
| rd_data | output | 8 | Selected count byte |
| pkt_rdy | output | 1 | Received packet ready for firmware |
| stall | output | 1 | Stall control bit |

## Verification
A wrong internal count shows up on `rd_data` at the very next read after the faulty edge, because the read path has no register. A missed increment or a missed clear is therefore visible one cycle after the stimulus. Saturation faults appear only once the count reaches `max_pkt`, so the bench runs a count past 255 so that a carry into the high byte is exposed. A stuck `pkt_rdy` is seen directly on its port, and indirectly through strobes that should or should not be counted.

// File: rtl/rx_byte_tally.sv
module rx_byte_tally #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rst,
  input  logic             byte_wr,
  input  logic             pkt_end,
  input  logic             out_tok,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic             wr_bit,
  input  logic             dir_tx,
  input  logic [CNT_W-1:0] max_pkt,
  input  logic             rd_sel,
  output logic [7:0]       rd_data,
  output logic             pkt_rdy,
  output logic             stall
);
  localparam int VIEW_W = 16;

  logic [CNT_W-1:0]  cnt;
  logic [VIEW_W-1:0] view;

  wire stall_wr  = wr_en && (wr_sel == 2'd2);
  wire rdy_wr    = wr_en && (wr_sel == 2'd3);
  wire stall_clr = stall_wr && !wr_bit;
  wire rdy_clr   = rdy_wr && !wr_bit;
  wire wipe      = bus_rst || out_tok || rdy_clr || stall_clr;
  wire bump      = byte_wr && !dir_tx && !pkt_rdy && (cnt < max_pkt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (wipe) cnt <= '0;
    else if (bump) cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pkt_rdy <= 1'b0;
    else if (bus_rst || rdy_clr)   pkt_rdy <= 1'b0;
    else if (pkt_end && !dir_tx)   pkt_rdy <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stall <= 1'b0;
    else if (bus_rst)  stall <= 1'b0;
    else if (stall_wr) stall <= wr_bit;
  end

  assign view    = VIEW_W'(cnt);
  assign rd_data = rd_sel ? view[15:8] : view[7:0];
endmodule

module rx_byte_tally_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rst,
  input logic             byte_wr,
  input logic             out_tok,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic             wr_bit,
  input logic             dir_tx,
  input logic [CNT_W-1:0] max_pkt,
  input logic             pkt_rdy,
  input logic             stall,
  input logic [CNT_W-1:0] cnt
);
  wire any_clr = bus_rst || out_tok || (wr_en && wr_sel[1] && !wr_bit);

  // R1
  bus_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (cnt == '0 && !pkt_rdy && !stall));

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr && cnt >= max_pkt && !any_clr) |=> cnt == $past(cnt));

  // R4
  hold_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_rdy && !any_clr) |=> $stable(cnt));

  // R5
  token_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_tok |=> cnt == '0);

  // R9
  tx_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_tx && !any_clr) |=> $stable(cnt));
endmodule

bind rx_byte_tally rx_byte_tally_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .byte_wr(byte_wr),
  .out_tok(out_tok), .wr_en(wr_en), .wr_sel(wr_sel), .wr_bit(wr_bit),
  .dir_tx(dir_tx), .max_pkt(max_pkt), .pkt_rdy(pkt_rdy), .stall(stall),
  .cnt(cnt)
);

// File: tb/rx_byte_tally_test.sv
module rx_byte_tally_test;
  localparam int CW = 10;
  localparam int VW = 30;
  localparam int NV = 28;

  logic clk = 1'b0, rst_n = 1'b0, bus_rst = 1'b0, byte_wr = 1'b0, pkt_end = 1'b0;
  logic out_tok = 1'b0, wr_en = 1'b0, wr_bit = 1'b0, dir_tx = 1'b0, rd_sel = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [CW-1:0] max_pkt = 10'd5;
  logic [7:0] rd_data;
  logic pkt_rdy, stall;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_byte_tally #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .byte_wr(byte_wr),
    .pkt_end(pkt_end), .out_tok(out_tok), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_bit(wr_bit), .dir_tx(dir_tx), .max_pkt(max_pkt), .rd_sel(rd_sel),
    .rd_data(rd_data), .pkt_rdy(pkt_rdy), .stall(stall));

  function automatic logic [VW-1:0] mk(input logic b, pe, ot, we,
      input logic [1:0] ws, input logic wb, tx,
      input logic [9:0] mx, ec, input logic er, es);
    return {b, pe, ot, we, ws, wb, tx, mx, ec, er, es};
  endfunction

  // fields: byte, end, token, wen, wsel, wbit, tx, max, exp count, exp ready, exp stall
  localparam logic [VW-1:0] VEC [NV] = '{
    mk(0,0,0,0,2'd0,0,0,10'd5,10'd0,0,0), // R1 idle after reset
    mk(1,0,0,0,2'd0,0,0,10'd5,10'd1,0,0), // R2
    mk(1,0,0,0,2'd0,0,0,10'd5,10'd2,0,0), // R2
    mk(1,0,0,0,2'd0,0,0,10'd5,10'd3,0,0), // R2
    mk(1,1,0,0,2'd0,0,0,10'd5,10'd4,1,0), // R4 strobe with end counted
    mk(1,0,0,0,2'd0,0,0,10'd5,10'd4,1,0), // R4 held while ready
    mk(0,0,0,1,2'd3,0,0,10'd5,10'd0,0,0), // R6 ready cleared
    mk(1,0,0,0,2'd0,0,0,10'd5,10'd1,0,0), // R2
    mk(1,0,0,0,2'd0,0,0,10'd5,10'd2,0,0), // R2
    mk(1,0,0,0,2'd0,0,0,10'd5,10'd3,0,0), // R2
    mk(1,0,0,0,2'd0,0,0,10'd5,10'd4,0,0), // R2
    mk(1,0,0,0,2'd0,0,0,10'd5,10'd5,0,0), // R3 reaches limit
    mk(1,0,0,0,2'd0,0,0,10'd5,10'd5,0,0), // R3 saturated
    mk(1,0,1,0,2'd0,0,0,10'd5,10'd0,0,0), // R5 R8 token beats strobe
    mk(1,0,0,0,2'd0,0,0,10'd5,10'd1,0,0), // R2
    mk(0,0,0,1,2'd2,1,0,10'd5,10'd1,0,1), // R7 stall set keeps count
    mk(1,0,0,1,2'd2,0,0,10'd5,10'd0,0,0), // R7 R8 stall clear beats strobe
    mk(1,0,0,0,2'd0,0,0,10'd5,10'd1,0,0), // R2
    mk(0,0,0,1,2'd0,1,0,10'd5,10'd1,0,0), // R11 low byte write ignored
    mk(0,0,0,1,2'd1,0,0,10'd5,10'd1,0,0), // R11 high byte write ignored
    mk(1,0,0,0,2'd0,0,1,10'd5,10'd1,0,0), // R9 strobe ignored in tx
    mk(0,1,0,0,2'd0,0,1,10'd5,10'd1,0,0), // R9 end ignored in tx
    mk(1,0,0,0,2'd0,0,0,10'd5,10'd2,0,0), // R2
    mk(0,1,0,0,2'd0,0,0,10'd5,10'd2,1,0), // R2 short packet held
    mk(0,0,1,0,2'd0,0,0,10'd5,10'd0,1,0), // R5 ready untouched
    mk(1,0,0,0,2'd0,0,0,10'd5,10'd0,1,0), // R4 still held
    mk(0,0,0,1,2'd3,1,0,10'd5,10'd0,1,0), // R6 write 1 has no effect
    mk(0,0,0,1,2'd3,0,0,10'd5,10'd0,0,0)  // R6
  };

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic read_count(output logic [15:0] v);
    rd_sel = 1'b0; #1; v[7:0] = rd_data;
    rd_sel = 1'b1; #1; v[15:8] = rd_data;
    rd_sel = 1'b0;
  endtask

  task automatic idle();
    byte_wr = 0; pkt_end = 0; out_tok = 0; wr_en = 0; wr_sel = 0; wr_bit = 0;
    bus_rst = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    logic [15:0] v;
    #3;
    read_count(v);
    check("R1 count in reset", int'(v), 0);
    check("R1 ready in reset", int'(pkt_rdy), 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {byte_wr, pkt_end, out_tok, wr_en, wr_sel, wr_bit, dir_tx} = VEC[i][29:22];
      max_pkt = VEC[i][21:12];
      @(negedge clk);
      idle();
      read_count(v);
      check($sformatf("vector %0d count", i), int'(v), int'(VEC[i][11:2]));
      check($sformatf("vector %0d ready", i), int'(pkt_rdy), int'(VEC[i][1]));
      check($sformatf("vector %0d stall", i), int'(stall), int'(VEC[i][0]));
    end
    dir_tx = 0;

    // R10 R3: wide count crosses into the high byte and saturates
    max_pkt = 10'd300;
    for (int k = 0; k < 305; k++) begin
      @(negedge clk); byte_wr = 1;
    end
    @(negedge clk); byte_wr = 0;
    rd_sel = 0; #1; check("R10 low byte", int'(rd_data), 44);
    rd_sel = 1; #1; check("R10 high byte zero fill", int'(rd_data), 1);
    rd_sel = 0;
    read_count(v);
    check("R3 saturated at 300", int'(v), 300);

    // R1 bus reset
    @(negedge clk); out_tok = 0; wr_en = 1; wr_sel = 2'd2; wr_bit = 1;
    @(negedge clk); idle(); pkt_end = 1;
    @(negedge clk); idle(); bus_rst = 1;
    @(negedge clk); idle();
    read_count(v);
    check("R1 bus reset count", int'(v), 0);
    check("R1 bus reset ready", int'(pkt_rdy), 0);
    check("R1 bus reset stall", int'(stall), 0);

    // R3 zero maximum
    max_pkt = 10'd0;
    @(negedge clk); byte_wr = 1;
    @(negedge clk); byte_wr = 0;
    read_count(v);
    check("R3 zero max", int'(v), 0);

    // R1 hardware reset mid packet
    max_pkt = 10'd8;
    @(negedge clk); byte_wr = 1;
    @(negedge clk); byte_wr = 1;
    @(negedge clk); byte_wr = 0;
    read_count(v);
    check("R2 before hard reset", int'(v), 2);
    rst_n = 0; #1;
    read_count(v);
    check("R1 hard reset count", int'(v), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule